// File: doc/BRIEF.md
# Ping-Pong Chirp Sample Buffer Controller

This block sits between a streaming sample source that delivers samples from four receive channels and a consumer that processes complete blocks of chirps. It owns two equal sample banks and uses them alternately. The producer writes into one bank while the consumer may read only the other bank. Each incoming sample is tagged with its channel. The controller keeps a separate sample counter for each channel, so the channels may arrive in any interleaving within a chirp.

When the programmed number of chirps has been stored, the controller swaps the roles of the two banks. It also pulses a chirp-available interrupt, which can serve as a software interrupt or as a hardware trigger for a DMA channel. Inside a bank the samples are laid out by channel first: all the samples of one channel, for every chirp in the bank, occupy one contiguous region.

The consumer acknowledges a bank with a release pulse. If the producer fills its bank before that release arrives, an overrun is flagged and the swap still takes place. Samples-per-chirp and chirps-per-bank are sampled while reset is held and again at every swap. Each bank holds `BANK_DEPTH` samples. A 32 KB bank of 16-bit samples corresponds to `BANK_DEPTH` = 16384. The configuration must satisfy 4 × samples × chirps ≤ `BANK_DEPTH`, with both values at least 1.

Top module: `pp_sample_buf_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `chirp_irq` = 0, `overrun` = 0 and `rd_bank` = 1. The producer writes bank 0 first.
- R2: An accepted sample from channel c that is number s within its channel in chirp k is stored in the write bank at word address c·(C·S) + k·S + s. S and C are the active samples per chirp and chirps per bank. The stored value is readable through `rd_addr`/`rd_data` once that bank becomes the read bank.
- R3: `chirp_irq` is high for exactly one cycle. That cycle is the one after the clock edge that accepted the last sample of the C-th chirp.
- R4: `rd_bank` inverts at the same edge that raises `chirp_irq` and holds its value at every other edge. New samples always go to bank `~rd_bank`.
- R5: Samples written by the producer never change the contents seen through the read port of the current read bank.
- R6: A chirp is complete when every one of the four channels has delivered S samples, regardless of the order in which the channels arrive.
- R7: A sample on a channel that already holds S samples in the current chirp is ignored. It is not stored and not counted.
- R8: Configuration changed while a bank is being filled takes effect only from the next swap. The bank being filled keeps the old layout and chirp count.
- R9: If no `rd_release` pulse has arrived since the previous swap, `overrun` pulses together with `chirp_irq`, and the swap still happens.
- R10: A `rd_release` given in the same cycle as the final sample of a bank counts as a release, so no overrun is flagged.
- R11: `rd_data` returns the word at `rd_addr` in bank `rd_bank` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while it is held |
| cfg_spc | input | SPC_W | Samples per chirp per channel (S) |
| cfg_cpb | input | CPB_W | Chirps per bank (C) |
| in_valid | input | 1 | Input sample present this cycle |
| in_chan | input | 2 | Receive channel of the input sample |
| in_data | input | DATA_W | Sample value |
| rd_release | input | 1 | Consumer pulse: done with the current read bank |
| rd_addr | input | ADDR_W | Word address within the read bank |
| rd_data | output | DATA_W | Read data, one cycle after `rd_addr` |
| rd_bank | output | 1 | Bank the consumer may read |
| chirp_irq | output | 1 | One-cycle chirp-available pulse / DMA trigger |
| overrun | output | 1 | One-cycle pulse: swap happened before the consumer released |

## Verification
The bench builds the block with `BANK_DEPTH` = 64, `SPC_W` = 4 and `CPB_W` = 3. With these values a bank fills in a few dozen cycles, so every swap, overrun and configuration change appears in a short run. The configurations used are 4 samples × 2 chirps, which fills 32 words, and 3 samples × 3 chirps, which fills 36 words. These place the channel regions at different strides, so an address formula wrong in any term is exposed. Fills use round-robin, channel-blocked and reversed channel orders, with extra samples on full channels. Reads of the idle bank overlap the writes throughout.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/pp_wr_addr_gen.sv
module pp_wr_addr_gen
    import pp_buf_pkg::*;
#(
    parameter int SPC_W  = 9,
    parameter int CPB_W  = 5,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [SPC_W-1:0]  spc,
    input  logic [CPB_W-1:0]  cpb,
    input  logic [ADDR_W-1:0] stride,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              buf_done
);

    logic [SPC_W-1:0]  cnt [NUM_CH];
    logic [ADDR_W-1:0] ch_off [NUM_CH];
    logic [NUM_CH-1:0] full_nxt;
    logic [CPB_W-1:0]  chirp_idx;
    logic [ADDR_W-1:0] chirp_base;
    logic              chirp_done;

    // a sample is taken only while its channel still has room in this chirp
    assign wr_en = in_valid && (cnt[in_chan] < spc);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == 0) begin : g_first
            assign ch_off[g] = '0;
        end else begin : g_next
            assign ch_off[g] = ch_off[g-1] + stride;
        end

        assign full_nxt[g] = (wr_en && in_chan == CH_W'(g))
                             ? ((cnt[g] + 1'b1) == spc)
                             : (cnt[g] == spc);

        // R7
        cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
            cnt[g] <= spc);
    end

    assign chirp_done = wr_en && (&full_nxt);
    assign buf_done   = chirp_done && (chirp_idx == (cpb - 1'b1));
    assign wr_addr    = ch_off[in_chan] + chirp_base + ADDR_W'(cnt[in_chan]);

    always_ff @(posedge clk) begin
        if (rst || buf_done) begin
            chirp_idx  <= '0;
            chirp_base <= '0;
        end else if (chirp_done) begin
            chirp_idx  <= chirp_idx + 1'b1;
            chirp_base <= chirp_base + ADDR_W'(spc);
        end
    end

    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (rst || chirp_done) begin
                cnt[c] <= '0;
            end else if (wr_en && in_chan == CH_W'(c)) begin
                cnt[c] <= cnt[c] + 1'b1;
            end
        end
    end

    // R6
    chirp_range_chk: assert property (@(posedge clk) disable iff (rst)
        chirp_idx < cpb);

endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
    import pp_buf_pkg::*;
#(
    parameter int SPC_W  = 9,
    parameter int CPB_W  = 5,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SPC_W-1:0]  cfg_spc,
    input  logic [CPB_W-1:0]  cfg_cpb,
    input  logic              buf_done,
    input  logic              rd_release,
    output logic [SPC_W-1:0]  spc,
    output logic [CPB_W-1:0]  cpb,
    output logic [ADDR_W-1:0] stride,
    output bank_e             wr_bank,
    output logic              chirp_irq,
    output logic              overrun
);

    localparam int PROD_W = SPC_W + CPB_W;

    logic [PROD_W-1:0] prod_in;
    logic              rd_busy;

    assign prod_in = PROD_W'(cfg_spc) * PROD_W'(cfg_cpb);

    always_ff @(posedge clk) begin
        if (rst) begin
            spc       <= cfg_spc;
            cpb       <= cfg_cpb;
            stride    <= ADDR_W'(prod_in);
            wr_bank   <= BANK_A;
            chirp_irq <= 1'b0;
            overrun   <= 1'b0;
            rd_busy   <= 1'b0;
        end else begin
            chirp_irq <= buf_done;
            overrun   <= buf_done && rd_busy && !rd_release;
            if (buf_done) begin
                spc     <= cfg_spc;
                cpb     <= cfg_cpb;
                stride  <= ADDR_W'(prod_in);
                wr_bank <= other_bank(wr_bank);
                rd_busy <= 1'b1;
            end else if (rd_release) begin
                rd_busy <= 1'b0;
            end
        end
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !buf_done |=> ($stable(spc) && $stable(cpb)));

endmodule

// File: rtl/pp_dual_bank.sv
module pp_dual_bank
    import pp_buf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int BANK_DEPTH = 1024,
    parameter int ADDR_W     = $clog2(BANK_DEPTH)
) (
    input  logic              clk,
    input  bank_e             wr_bank,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] bank_rd [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam bank_e THIS = (g == 0) ? BANK_A : BANK_B;
        logic [DATA_W-1:0] mem [BANK_DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == THIS) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[g] = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        rd_data <= bank_rd[other_bank(wr_bank)];
    end

endmodule

// File: rtl/pp_sample_buf_ctrl.sv
module pp_sample_buf_ctrl
    import pp_buf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SPC_W      = 9,
    parameter int CPB_W      = 5,
    parameter int BANK_DEPTH = 1024,
    parameter int ADDR_W     = $clog2(BANK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SPC_W-1:0]  cfg_spc,
    input  logic [CPB_W-1:0]  cfg_cpb,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_release,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bank,
    output logic              chirp_irq,
    output logic              overrun
);

    logic [SPC_W-1:0]  spc;
    logic [CPB_W-1:0]  cpb;
    logic [ADDR_W-1:0] stride;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              buf_done;
    bank_e             wr_bank;

    pp_wr_addr_gen #(.SPC_W(SPC_W), .CPB_W(CPB_W), .ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_chan  (in_chan),
        .spc      (spc),
        .cpb      (cpb),
        .stride   (stride),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .buf_done (buf_done)
    );

    pp_swap_ctrl #(.SPC_W(SPC_W), .CPB_W(CPB_W), .ADDR_W(ADDR_W)) u_swap (
        .clk        (clk),
        .rst        (rst),
        .cfg_spc    (cfg_spc),
        .cfg_cpb    (cfg_cpb),
        .buf_done   (buf_done),
        .rd_release (rd_release),
        .spc        (spc),
        .cpb        (cpb),
        .stride     (stride),
        .wr_bank    (wr_bank),
        .chirp_irq  (chirp_irq),
        .overrun    (overrun)
    );

    pp_dual_bank #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_bank (wr_bank),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign rd_bank = logic'(other_bank(wr_bank));

    // R3
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chirp_irq |=> !chirp_irq);

    // R4
    bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
        chirp_irq |-> (rd_bank != $past(rd_bank)));

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chirp_irq |-> $stable(rd_bank));

    // R9
    overrun_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> chirp_irq);

endmodule

// File: tb/pp_sample_buf_ctrl_tb.sv
module pp_sample_buf_ctrl_tb;

    localparam int DW = 16;
    localparam int SW = 4;
    localparam int CW = 3;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] cfg_spc = SW'(4);
    logic [CW-1:0] cfg_cpb = CW'(2);
    logic          in_valid = 1'b0;
    logic [1:0]    in_chan = '0;
    logic [DW-1:0] in_data = '0;
    logic          rd_release = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_bank;
    logic          chirp_irq;
    logic          overrun;

    always #2 clk = ~clk;

    pp_sample_buf_ctrl #(.DATA_W(DW), .SPC_W(SW), .CPB_W(CW), .BANK_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_spc(cfg_spc), .cfg_cpb(cfg_cpb),
        .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .rd_release(rd_release), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_bank(rd_bank), .chirp_irq(chirp_irq), .overrun(overrun)
    );

    typedef struct { int ch; int d; } smp_t;

    int          m_cnt [4];
    int          m_chirp, m_S, m_C, m_wsel, m_busy;
    logic [15:0] mbank [2][DEPTH];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          chk_rd = 0;
    bit          finished = 0;
    string       tag = "reset";
    smp_t        q[$];

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    // one clock: drive, advance the model, compare after the edge
    task automatic cyc(bit v, int ch, int d, bit rel, int ra);
        int exp_irq = 0;
        int exp_ovr = 0;
        int exp_rd;
        bit swapped = 0;
        in_valid = v; in_chan = ch[1:0]; in_data = d[15:0];
        rd_release = rel; rd_addr = ra[AW-1:0];
        exp_rd = mbank[1-m_wsel][ra];
        // R6 R7: per-channel counting, overflow samples dropped
        if (v && m_cnt[ch] < m_S) begin
            mbank[m_wsel][ch*m_C*m_S + m_chirp*m_S + m_cnt[ch]] = d[15:0];
            m_cnt[ch]++;
            if (m_cnt[0] == m_S && m_cnt[1] == m_S && m_cnt[2] == m_S && m_cnt[3] == m_S) begin
                for (int c = 0; c < 4; c++) m_cnt[c] = 0;
                m_chirp++;
                if (m_chirp == m_C) begin
                    swapped = 1;
                    exp_irq = 1;
                    exp_ovr = (m_busy == 1 && !rel) ? 1 : 0;
                    m_wsel  = 1 - m_wsel;
                    m_busy  = 1;
                    m_chirp = 0;
                    m_S = int'(cfg_spc);   // R8: new config only here
                    m_C = int'(cfg_cpb);
                end
            end
        end
        if (!swapped && rel) m_busy = 0;
        @(posedge clk); #1;
        check("R3", int'(chirp_irq), exp_irq);
        check("R4", int'(rd_bank), 1 - m_wsel);
        check(exp_ovr ? "R9" : "R10", int'(overrun), exp_ovr);
        // R2 R5 R11: read port returns the idle bank, untouched by writes
        if (chk_rd) check("R2", int'(rd_data), int'(exp_rd));
    endtask

    task automatic build(int mode, bit extras, int base);
        int n = 0;
        q.delete();
        for (int k = 0; k < m_C; k++) begin
            if (mode == 1) begin
                for (int j = 0; j < 4; j++) begin
                    int ch = 3 - j;
                    for (int s = 0; s < m_S; s++) begin q.push_back('{ch, base + n}); n++; end
                    if (extras && j < 3) begin q.push_back('{ch, 16'hBEEF}); end
                end
            end else begin
                for (int s = 0; s < m_S; s++)
                    for (int j = 0; j < 4; j++) begin
                        int ch = (mode == 2) ? 3 - ((j + s) % 4) : j;
                        q.push_back('{ch, base + n}); n++;
                    end
            end
        end
    endtask

    task automatic play(bit rel_last, bit rd_on, int rd_mod);
        chk_rd = rd_on;
        for (int i = 0; i < q.size(); i++)
            cyc(1, q[i].ch, q[i].d, rel_last && (i == q.size() - 1), rd_on ? i % rd_mod : 0);
    endtask

    task automatic readback(int words, bit rel_end);
        chk_rd = 1;
        for (int a = 0; a < words; a++) cyc(0, 0, 0, rel_end && a == words - 1, a);
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog [%s] actual=hung expected=done", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int a = 0; a < DEPTH; a++) mbank[b][a] = '0;
        for (int c = 0; c < 4; c++) m_cnt[c] = 0;
        m_chirp = 0; m_S = 4; m_C = 2; m_wsel = 0; m_busy = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check("R1", int'(chirp_irq), 0);
        check("R1", int'(overrun), 0);
        check("R1", int'(rd_bank), 1);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0);

        // R2 R6: round-robin fill of bank 0, then read it back and release
        tag = "rr fill";
        build(0, 0, 100); play(0, 0, 1);
        tag = "readback bank0";
        readback(32, 1);

        // R7 R8 R5: blocked order with extras, config changed mid-bank
        tag = "blocked fill";
        cfg_spc = SW'(3); cfg_cpb = CW'(3);
        build(1, 1, 500); play(0, 1, 32);

        // R9: no release since last swap
        tag = "overrun fill";
        build(2, 0, 900); play(0, 1, 32);

        // R10: release with the final sample
        tag = "release on last";
        build(0, 0, 1300); play(1, 1, 36);
        tag = "readback 3x3";
        readback(36, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule